// File: doc/BRIEF.md
# Multi-Accumulator HI/LO Multiply Unit

This block is the multiply side of a 32-bit integer core. It holds four HI/LO accumulator pairs. It executes signed and unsigned multiply, multiply-add and multiply-subtract into a selected pair, and it moves values between the general registers and HI or LO. The surrounding pipeline passes in the instruction word and the two source operand values with a valid strobe. For each move-from, the unit hands back a value for the register file, together with a write-enable pulse and the destination index.

The pair is named by a 2-bit field of the instruction. Which bits hold that field depends on the operation. Pair 0 is always usable. Pairs 1 to 3 belong to the signal-processing extension: using one while that extension is disabled raises an unusable-extension exception, and the instruction then has no effect.

All state lives in the unit. Every result appears one clock after the strobe, and the outputs are registered.

Top module: `hilo_mac_unit`

## Requirements
- R1: Reset (synchronous, active high) clears all four HI and all four LO registers to zero and deasserts both the write-enable and the exception output.
- R2: Every operation completes one clock after a valid strobe. A move-from drives the write-enable output high for that one cycle only, with the destination index taken from instruction bits 15:11 and the selected register value on the data output.
- R3: For move-from-HI and move-from-LO the pair index is instruction bits 22:21. For move-to and all multiply forms it is bits 12:11. The primary opcode is bits 31:26 and the function code is bits 5:0.
- R4: When the selected pair index is nonzero and the extension-enable input is low, the exception output pulses one cycle after the strobe. No HI, LO or register write happens.
- R5: A move-from whose destination index (bits 15:11) is zero is a no-op: no write-enable, no exception even with a nonzero pair and the extension disabled, and no state change.
- R6: Move-to-HI and move-to-LO write the first source operand into the selected register. When the source index (bits 25:21) is zero they write zero instead, whatever the operand value.
- R7: Signed multiply (opcode 0x00, function 0x18) forms the 64-bit product of the sign-extended operands. Unsigned multiply (opcode 0x00, function 0x19) zero-extends both operands. The low half goes to LO and the high half to HI of the selected pair.
- R8: Multiply-add (opcode 0x1C, function 0x00 signed, 0x01 unsigned) adds the product to the selected HI:LO taken as one 64-bit value, modulo 2^64.
- R9: Multiply-subtract (opcode 0x1C, function 0x04 signed, 0x05 unsigned) replaces the selected HI:LO with HI:LO minus the product, modulo 2^64.
- R10: Any other opcode or function code changes no HI or LO register, writes no register and raises no exception.
- R11: A move-to changes only the addressed register (HI for function 0x11, LO for 0x13) of the selected pair. The other half and the other pairs keep their values. Move-from codes are 0x10 for HI and 0x12 for LO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction strobe |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | First source operand value |
| rt_val_i | input | 32 | Second source operand value |
| dsp_en_i | input | 1 | Extension enable; pairs 1 to 3 need it |
| gpr_we_o | output | 1 | Register write-enable pulse |
| gpr_idx_o | output | 5 | Destination register index |
| gpr_data_o | output | 32 | Value to write back |
| dsp_exc_o | output | 1 | Unusable-extension exception pulse |

## Verification
The bench builds the unit with its default parameters: 32-bit data and four pairs. With these defaults both selector fields are two bits wide, so every pair is reachable through both instruction layouts. This lets the bench show that a move-to through bits 12:11 and a move-from through bits 22:21 reach the same pair. The 32-bit width also makes the carry out of LO into HI and the 2^64 wrap of multiply-add and multiply-subtract reachable with small operands.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
  localparam int INSTR_W   = 32;
  localparam int REG_IDX_W = 5;

  localparam int OPC_LSB   = 26;
  localparam int FN_W      = 6;
  localparam int RS_LSB    = 21;
  localparam int RD_LSB    = 11;
  localparam int MF_SEL_LSB = 21;
  localparam int OT_SEL_LSB = 11;

  localparam logic [5:0] OPC_BASE = 6'h00;
  localparam logic [5:0] OPC_EXT2 = 6'h1C;

  localparam logic [5:0] FN_MFHI  = 6'h10;
  localparam logic [5:0] FN_MTHI  = 6'h11;
  localparam logic [5:0] FN_MFLO  = 6'h12;
  localparam logic [5:0] FN_MTLO  = 6'h13;
  localparam logic [5:0] FN_MULS  = 6'h18;
  localparam logic [5:0] FN_MULU  = 6'h19;
  localparam logic [5:0] FN_MADDS = 6'h00;
  localparam logic [5:0] FN_MADDU = 6'h01;
  localparam logic [5:0] FN_MSUBS = 6'h04;
  localparam logic [5:0] FN_MSUBU = 6'h05;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_MFHI,
    OP_MFLO,
    OP_MTHI,
    OP_MTLO,
    OP_MUL,
    OP_MADD,
    OP_MSUB
  } hilo_op_e;
endpackage

// File: rtl/hilo_decode.sv
module hilo_decode
  import hilo_pkg::*;
#(
  parameter int ACC_IDX_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_i,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic                 dsp_en_i,
  output hilo_op_e             op_o,
  output logic                 sgn_o,
  output logic [ACC_IDX_W-1:0] acc_idx_o,
  output logic [REG_IDX_W-1:0] rd_idx_o,
  output logic                 src_zero_o,
  output logic                 we_hi_o,
  output logic                 we_lo_o,
  output logic                 rd_req_o,
  output logic                 exc_o
);
  logic [5:0]           opc;
  logic [FN_W-1:0]      fn;
  logic [REG_IDX_W-1:0] rs_idx;
  hilo_op_e             op;
  logic                 is_mf;
  logic                 no_op;
  logic                 go;
  logic                 unused_fields;

  assign opc    = instr_i[OPC_LSB +: 6];
  assign fn     = instr_i[0 +: FN_W];
  assign rs_idx = instr_i[RS_LSB +: REG_IDX_W];
  assign rd_idx_o = instr_i[RD_LSB +: REG_IDX_W];
  assign unused_fields = ^{instr_i[20:16], instr_i[10:6]};

  always_comb begin
    op    = OP_NONE;
    sgn_o = 1'b0;
    if (opc == OPC_BASE) begin
      unique case (fn)
        FN_MFHI: op = OP_MFHI;
        FN_MFLO: op = OP_MFLO;
        FN_MTHI: op = OP_MTHI;
        FN_MTLO: op = OP_MTLO;
        FN_MULS: begin op = OP_MUL; sgn_o = 1'b1; end
        FN_MULU: op = OP_MUL;
        default: op = OP_NONE;
      endcase
    end else if (opc == OPC_EXT2) begin
      unique case (fn)
        FN_MADDS: begin op = OP_MADD; sgn_o = 1'b1; end
        FN_MADDU: op = OP_MADD;
        FN_MSUBS: begin op = OP_MSUB; sgn_o = 1'b1; end
        FN_MSUBU: op = OP_MSUB;
        default:  op = OP_NONE;
      endcase
    end
  end

  assign op_o  = op;
  assign is_mf = (op == OP_MFHI) || (op == OP_MFLO);

  // The selector position depends on the operation class
  assign acc_idx_o = is_mf ? instr_i[MF_SEL_LSB +: ACC_IDX_W]
                           : instr_i[OT_SEL_LSB +: ACC_IDX_W];

  assign src_zero_o = (rs_idx == '0);
  assign no_op = (op == OP_NONE) || (is_mf && (rd_idx_o == '0));
  assign exc_o = valid_i && !no_op && (acc_idx_o != '0) && !dsp_en_i;
  assign go    = valid_i && !no_op && !exc_o;

  assign we_hi_o  = go && (op == OP_MTHI || op == OP_MUL || op == OP_MADD || op == OP_MSUB);
  assign we_lo_o  = go && (op == OP_MTLO || op == OP_MUL || op == OP_MADD || op == OP_MSUB);
  assign rd_req_o = go && is_mf;

  // R4
  excl_write_chk: assert property (@(posedge clk) disable iff (rst)
    exc_o |-> !(we_hi_o || we_lo_o || rd_req_o));

  // R10
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (op_o == OP_NONE) |-> !(we_hi_o || we_lo_o || rd_req_o || exc_o));
endmodule

// File: rtl/hilo_arith.sv
module hilo_arith
  import hilo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  hilo_op_e          op_i,
  input  logic              sgn_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              src_zero_i,
  input  logic [DATA_W-1:0] cur_hi_i,
  input  logic [DATA_W-1:0] cur_lo_i,
  output logic [DATA_W-1:0] new_hi_o,
  output logic [DATA_W-1:0] new_lo_o
);
  localparam int WIDE_W = 2 * DATA_W;

  logic [WIDE_W-1:0] ext_a;
  logic [WIDE_W-1:0] ext_b;
  logic [WIDE_W-1:0] prod;
  logic [WIDE_W-1:0] acc;
  logic [WIDE_W-1:0] res;
  logic [DATA_W-1:0] mt_val;

  assign ext_a = {{DATA_W{sgn_i & a_i[DATA_W-1]}}, a_i};
  assign ext_b = {{DATA_W{sgn_i & b_i[DATA_W-1]}}, b_i};
  // Low 2W bits of the extended product equal the true product in both forms
  assign prod  = ext_a * ext_b;
  assign acc   = {cur_hi_i, cur_lo_i};
  assign mt_val = src_zero_i ? '0 : a_i;

  always_comb begin
    unique case (op_i)
      OP_MUL:  res = prod;
      OP_MADD: res = acc + prod;
      OP_MSUB: res = acc - prod;
      OP_MTHI: res = {mt_val, cur_lo_i};
      OP_MTLO: res = {cur_hi_i, mt_val};
      default: res = acc;
    endcase
  end

  assign new_hi_o = res[WIDE_W-1:DATA_W];
  assign new_lo_o = res[DATA_W-1:0];
endmodule

// File: rtl/hilo_acc_bank.sv
module hilo_acc_bank #(
  parameter int DATA_W  = 32,
  parameter int NUM_ACC = 4,
  localparam int IDX_W  = $clog2(NUM_ACC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              we_hi_i,
  input  logic              we_lo_i,
  input  logic [DATA_W-1:0] wr_hi_i,
  input  logic [DATA_W-1:0] wr_lo_i,
  output logic [DATA_W-1:0] rd_hi_o,
  output logic [DATA_W-1:0] rd_lo_o
);
  logic [DATA_W-1:0] hi_q [NUM_ACC];
  logic [DATA_W-1:0] lo_q [NUM_ACC];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ACC; i++) begin
        hi_q[i] <= '0;
        lo_q[i] <= '0;
      end
    end else begin
      if (we_hi_i) hi_q[idx_i] <= wr_hi_i;
      if (we_lo_i) lo_q[idx_i] <= wr_lo_i;
    end
  end

  assign rd_hi_o = hi_q[idx_i];
  assign rd_lo_o = lo_q[idx_i];

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_keep
    // R11
    hi_keep_chk: assert property (@(posedge clk) disable iff (rst)
      !(we_hi_i && idx_i == IDX_W'(g)) |=> $stable(hi_q[g]));
    // R11
    lo_keep_chk: assert property (@(posedge clk) disable iff (rst)
      !(we_lo_i && idx_i == IDX_W'(g)) |=> $stable(lo_q[g]));
  end
endmodule

// File: rtl/hilo_mac_unit.sv
module hilo_mac_unit
  import hilo_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_ACC = 4,
  localparam int ACC_IDX_W = $clog2(NUM_ACC)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_i,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic [DATA_W-1:0]    rs_val_i,
  input  logic [DATA_W-1:0]    rt_val_i,
  input  logic                 dsp_en_i,
  output logic                 gpr_we_o,
  output logic [REG_IDX_W-1:0] gpr_idx_o,
  output logic [DATA_W-1:0]    gpr_data_o,
  output logic                 dsp_exc_o
);
  hilo_op_e             op;
  logic                 sgn;
  logic [ACC_IDX_W-1:0] acc_idx;
  logic [REG_IDX_W-1:0] rd_idx;
  logic                 src_zero;
  logic                 we_hi, we_lo, rd_req, exc;
  logic [DATA_W-1:0]    cur_hi, cur_lo, new_hi, new_lo;

  hilo_decode #(.ACC_IDX_W(ACC_IDX_W)) u_dec (
    .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i),
    .dsp_en_i(dsp_en_i), .op_o(op), .sgn_o(sgn), .acc_idx_o(acc_idx),
    .rd_idx_o(rd_idx), .src_zero_o(src_zero), .we_hi_o(we_hi),
    .we_lo_o(we_lo), .rd_req_o(rd_req), .exc_o(exc)
  );

  hilo_acc_bank #(.DATA_W(DATA_W), .NUM_ACC(NUM_ACC)) u_bank (
    .clk(clk), .rst(rst), .idx_i(acc_idx), .we_hi_i(we_hi), .we_lo_i(we_lo),
    .wr_hi_i(new_hi), .wr_lo_i(new_lo), .rd_hi_o(cur_hi), .rd_lo_o(cur_lo)
  );

  hilo_arith #(.DATA_W(DATA_W)) u_arith (
    .op_i(op), .sgn_i(sgn), .a_i(rs_val_i), .b_i(rt_val_i),
    .src_zero_i(src_zero), .cur_hi_i(cur_hi), .cur_lo_i(cur_lo),
    .new_hi_o(new_hi), .new_lo_o(new_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gpr_we_o   <= 1'b0;
      gpr_idx_o  <= '0;
      gpr_data_o <= '0;
      dsp_exc_o  <= 1'b0;
    end else begin
      gpr_we_o  <= rd_req;
      dsp_exc_o <= exc;
      if (rd_req) begin
        gpr_idx_o  <= rd_idx;
        gpr_data_o <= (op == OP_MFHI) ? cur_hi : cur_lo;
      end
    end
  end

  // R2
  we_after_valid_chk: assert property (@(posedge clk) disable iff (rst)
    gpr_we_o |-> $past(valid_i));
  // R4
  exc_needs_disable_chk: assert property (@(posedge clk) disable iff (rst)
    dsp_exc_o |-> ($past(valid_i) && !$past(dsp_en_i)));
  // R4
  exc_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    dsp_exc_o |-> !gpr_we_o);
  // R5
  no_zero_dest_chk: assert property (@(posedge clk) disable iff (rst)
    gpr_we_o |-> (gpr_idx_o != '0));
endmodule

// File: tb/hilo_mac_unit_test.sv
module hilo_mac_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic        dsp_en = 1'b0;
  logic        gpr_we;
  logic [4:0]  gpr_idx;
  logic [31:0] gpr_data;
  logic        dsp_exc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] mh [4];
  logic [31:0] ml [4];

  always #5 clk = ~clk;

  hilo_mac_unit uut (
    .clk(clk), .rst(rst), .valid_i(valid), .instr_i(instr),
    .rs_val_i(rs_val), .rt_val_i(rt_val), .dsp_en_i(dsp_en),
    .gpr_we_o(gpr_we), .gpr_idx_o(gpr_idx), .gpr_data_o(gpr_data),
    .dsp_exc_o(dsp_exc)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] i_sp(input logic [4:0] rs, input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, rs, 5'd0, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] i_s2(input logic [1:0] acc, input logic [5:0] fn);
    return {6'h1C, 5'd1, 5'd2, 3'd0, acc, 5'd0, fn};
  endfunction

  function automatic logic [63:0] prod(input logic [31:0] a, input logic [31:0] b, input bit s);
    longint pa, pb;
    if (s) begin pa = longint'(signed'(a)); pb = longint'(signed'(b)); end
    else   begin pa = longint'({32'd0, a}); pb = longint'({32'd0, b}); end
    return 64'(pa * pb);
  endfunction

  // Drive at falling edge; results are visible at the next falling edge
  task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b, input logic en);
    instr = ins; rs_val = a; rt_val = b; dsp_en = en; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic read_acc(input string req, input int acc, input bit hi, output logic [31:0] v);
    issue(i_sp({3'd0, 2'(acc)}, 5'd9, hi ? 6'h10 : 6'h12), 32'hDEAD, 0, 1'b1);
    chk({req, " mf we"}, 64'(gpr_we), 64'd1);
    chk({req, " mf idx"}, 64'(gpr_idx), 64'd9);
    v = gpr_data;
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      read_acc(req, a, 1'b1, v); chk({req, " hi"}, 64'(v), 64'(mh[a]));
      read_acc(req, a, 1'b0, v); chk({req, " lo"}, 64'(v), 64'(ml[a]));
    end
  endtask

  task automatic mt(input int acc, input bit hi, input logic [31:0] v);
    issue(i_sp(5'd3, {3'd0, 2'(acc)}, hi ? 6'h11 : 6'h13), v, 0, 1'b1);
    if (hi) mh[acc] = v; else ml[acc] = v;
  endtask

  task automatic t_reset;
    chk("R1 we", 64'(gpr_we), 0);
    chk("R1 exc", 64'(dsp_exc), 0);
    check_all("R1");
  endtask

  task automatic t_move;
    logic [31:0] v;
    mt(2, 1'b1, 32'h1234_5678);
    mt(2, 1'b0, 32'h9ABC_DEF0);
    mt(1, 1'b0, 32'h0BAD_F00D);
    check_all("R11");
    // R3 move-from with pair in bits 22:21 and rd = 17
    issue(i_sp(5'd2, 5'd17, 6'h10), 0, 0, 1'b1);
    chk("R3 idx", 64'(gpr_idx), 64'd17);
    chk("R3 data", 64'(gpr_data), 64'h1234_5678);
    @(negedge clk);
    chk("R2 pulse ends", 64'(gpr_we), 0);
    // R6 source index zero writes zero
    issue(i_sp(5'd0, 5'd2, 6'h11), 32'hFFFF_FFFF, 0, 1'b1);
    mh[2] = 0;
    read_acc("R6", 2, 1'b1, v); chk("R6 zero", 64'(v), 0);
  endtask

  task automatic t_mult;
    issue({6'h00, 5'd1, 5'd2, 5'd1, 5'd0, 6'h18}, 32'hFFFF_FFFD, 32'd5, 1'b1);
    {mh[1], ml[1]} = prod(32'hFFFF_FFFD, 32'd5, 1);
    chk("R2 no we", 64'(gpr_we), 0);
    issue({6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h19}, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    {mh[3], ml[3]} = prod(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    chk("R7 model", {mh[3], ml[3]}, 64'hFFFF_FFFE_0000_0001);
    check_all("R7");
  endtask

  task automatic t_madd;
    mt(0, 1'b1, 32'h7FFF_FFFF);
    mt(0, 1'b0, 32'hFFFF_FFFF);
    issue(i_s2(2'd0, 6'h01), 32'd1, 32'd1, 1'b0);
    {mh[0], ml[0]} = {mh[0], ml[0]} + prod(1, 1, 0);
    chk("R8 carry", {mh[0], ml[0]}, 64'h8000_0000_0000_0000);
    issue(i_s2(2'd1, 6'h00), 32'hFFFF_FFFE, 32'd7, 1'b1);
    {mh[1], ml[1]} = {mh[1], ml[1]} + prod(32'hFFFF_FFFE, 7, 1);
    check_all("R8");
  endtask

  task automatic t_msub;
    mt(2, 1'b1, 0); mt(2, 1'b0, 0);
    issue(i_s2(2'd2, 6'h05), 32'd1, 32'd1, 1'b1);
    {mh[2], ml[2]} = 64'd0 - prod(1, 1, 0);
    chk("R9 wrap", {mh[2], ml[2]}, 64'hFFFF_FFFF_FFFF_FFFF);
    issue(i_s2(2'd3, 6'h04), 32'hFFFF_FFFF, 32'h8000_0000, 1'b1);
    {mh[3], ml[3]} = {mh[3], ml[3]} - prod(32'hFFFF_FFFF, 32'h8000_0000, 1);
    check_all("R9");
  endtask

  task automatic t_dsp_exc;
    issue({6'h00, 5'd1, 5'd2, 5'd2, 5'd0, 6'h18}, 32'd3, 32'd3, 1'b0);
    chk("R4 exc mul", 64'(dsp_exc), 1);
    chk("R4 no we", 64'(gpr_we), 0);
    @(negedge clk);
    chk("R4 pulse ends", 64'(dsp_exc), 0);
    issue(i_sp(5'd3, 5'd4, 6'h10), 0, 0, 1'b0);
    chk("R4 exc mf", 64'(dsp_exc), 1);
    chk("R4 mf no we", 64'(gpr_we), 0);
    issue(i_sp(5'd0, 5'd6, 6'h12), 0, 0, 1'b0);
    chk("R4 pair0 no exc", 64'(dsp_exc), 0);
    chk("R4 pair0 we", 64'(gpr_we), 1);
    check_all("R4");
  endtask

  task automatic t_mf_zero;
    issue(i_sp(5'd3, 5'd0, 6'h10), 0, 0, 1'b0);
    chk("R5 no exc", 64'(dsp_exc), 0);
    chk("R5 no we", 64'(gpr_we), 0);
  endtask

  task automatic t_unknown;
    issue({6'h00, 5'd1, 5'd2, 5'd1, 5'd0, 6'h1A}, 32'd9, 32'd9, 1'b0);
    chk("R10 no exc", 64'(dsp_exc), 0);
    chk("R10 no we", 64'(gpr_we), 0);
    issue(i_s2(2'd1, 6'h02), 32'd9, 32'd9, 1'b1);
    issue({6'h08, 5'd1, 5'd2, 5'd1, 5'd0, 6'h18}, 32'd9, 32'd9, 1'b1);
    check_all("R10");
  endtask

  initial begin
    for (int a = 0; a < 4; a++) begin mh[a] = '1; ml[a] = '1; end
    repeat (3) @(negedge clk);
    // R1 issue writes during reset, they must be discarded
    instr = i_sp(5'd3, 5'd1, 6'h11); rs_val = 32'h55; dsp_en = 1'b1; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0; rst = 1'b0;
    for (int a = 0; a < 4; a++) begin mh[a] = 0; ml[a] = 0; end
    @(negedge clk);
    t_reset();
    t_move();
    t_mult();
    t_madd();
    t_msub();
    t_dsp_exc();
    t_mf_zero();
    t_unknown();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule